// File: doc/BRIEF.md
# Optical Drive Command Response Sequencer

This block is the command front end of an optical-disc controller. Software first pushes up to three argument bytes into a small argument queue. It then writes a command code. The sequencer accepts the command and raises a busy flag. After a fixed delay it posts a first response, which is usually an acknowledge. Some commands follow that with a second completion response, which arrives one acknowledge delay later. Each response holds up to six bytes and a type code. An interrupt line is raised when the response type matches the software interrupt-enable mask. Software reads the response bytes by index and releases the response with an acknowledge strobe.

The block keeps a drive status byte. It also keeps a minute:second:frame sector address, which the set-location command loads from BCD arguments. While a read is running, a data-ready response is posted once per sector interval and the address steps by one frame. A mode bit halves the interval. A second mode bit makes the read stop by itself when the media side reports an end-of-file sector. Media access, audio decoding and the sector data path are outside this block.

Top module: `odc_cmd_sequencer`

## Requirements
- R1: An accepted command sets `busy_o` on the following cycle. `busy_o` clears, and the first response becomes valid, exactly ACK_DELAY clock edges after the edge that accepted the command. After reset, busy, status, response valid, interrupt and address are all zero.
- R2: The pause command (0x09) posts its first response PAUSE_DELAY edges after acceptance, not ACK_DELAY. That response byte is the status before the pause. After it, the reading bit (5) and the playing bit (7) are clear.
- R3: A command is ignored when it is written while `busy_o` is high. A code outside the supported set is also ignored. Ignored means no busy, no response and no state change. The supported codes are 0x01 nop, 0x02 set-location, 0x03 play, 0x06 read, 0x08 stop, 0x09 pause, 0x0A init, 0x0D set-filter, 0x0E set-mode, 0x0F get-mode, 0x15 seek, 0x1A identify, 0x1C reset and 0x1E table-of-contents.
- R4: The status bits are: bit 1 motor on, bit 5 reading, bit 6 seeking, bit 7 playing. Commands other than nop and stop set the motor bit. Play acknowledges with the status before its playing bit is set, and sets bit 7 afterwards.
- R5: Seek, identify, table-of-contents, init and pause each post an acknowledge and then a completion. The completion comes ACK_DELAY edges after the acknowledge. If the previous response is still unacknowledged, the completion waits and is posted on the edge after the acknowledge strobe.
- R6: The acknowledge response of a seek carries, and leaves in the status, bit 6 set. Its completion carries, and leaves, bit 6 clear.
- R7: Stop clears bits 1, 5 and 7 and posts a single completion-type response. Init and reset force the status to 0x02. Reset posts no second response.
- R8: Set-location loads minute, second and frame from argument bytes one, two and three. Each argument is read as two BCD digits and converted to binary.
- R9: Read acknowledges with the status before bit 5 is set, then sets bit 5. It posts a data-ready response carrying the status every READ_INTERVAL edges, or every READ_INTERVAL/2 edges when mode bit 7 is set. Each such response advances the address: frames run 0 to 74, and their wrap increments seconds, which run 0 to 59; the seconds wrap increments minutes.
- R10: When mode bit 1 is set and `sector_eof` is high at a data-ready response, that response is still posted, bit 5 clears and no further sectors are posted.
- R11: Set-filter stores argument one as the file number and argument two as the channel. Get-mode returns six bytes: status, mode, file, channel, 0, 0. An index at or beyond the response length reads 0.
- R12: Response types are 1 for data-ready, 2 for completion and 3 for acknowledge. `irq_o` is high while a response is valid and its type ANDed with the 3-bit enable mask is nonzero. `irq_ack` invalidates the response on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| param_wr | input | 1 | Push one argument byte |
| param_in | input | 8 | Argument byte |
| cmd_wr | input | 1 | Write a command code |
| cmd_in | input | 8 | Command code |
| irq_mask_wr | input | 1 | Load the interrupt-enable mask |
| irq_mask_in | input | 3 | Interrupt-enable mask value |
| irq_ack | input | 1 | Release the current response |
| sector_eof | input | 1 | End-of-file flag of the sector being delivered |
| resp_idx | input | 3 | Response byte index |
| busy_o | output | 1 | Command waiting for its first response |
| status_o | output | 8 | Drive status byte |
| resp_valid_o | output | 1 | A response is posted |
| resp_type_o | output | 3 | Type of the posted response |
| resp_len_o | output | 3 | Byte count of the posted response |
| resp_byte_o | output | 8 | Response byte selected by resp_idx |
| irq_o | output | 1 | Interrupt request |
| msf_min_o | output | 7 | Sector address minutes |
| msf_sec_o | output | 6 | Sector address seconds |
| msf_frm_o | output | 7 | Sector address frames |

## Verification
The bench builds the block with ACK_DELAY 8, PAUSE_DELAY 40 and READ_INTERVAL 20. At these values every response delay can be counted edge by edge. A single read sweep of ninety sectors, started just below a minute boundary, also fits in a short run. That sweep crosses both the frame carry and the second carry, and the bench checks every address against linear arithmetic on a frame count. The short pause delay lets the bench hold a response unacknowledged longer than the completion delay, which exercises the deferred completion.

// File: rtl/odc_pkg.sv
`timescale 1ns/1ps
package odc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_DONE = 2'd2
    } stage_e;

    localparam logic [7:0] OP_NOP     = 8'h01;
    localparam logic [7:0] OP_SETLOC  = 8'h02;
    localparam logic [7:0] OP_PLAY    = 8'h03;
    localparam logic [7:0] OP_READ    = 8'h06;
    localparam logic [7:0] OP_STOP    = 8'h08;
    localparam logic [7:0] OP_PAUSE   = 8'h09;
    localparam logic [7:0] OP_INIT    = 8'h0A;
    localparam logic [7:0] OP_FILTER  = 8'h0D;
    localparam logic [7:0] OP_SETMODE = 8'h0E;
    localparam logic [7:0] OP_GETMODE = 8'h0F;
    localparam logic [7:0] OP_SEEK    = 8'h15;
    localparam logic [7:0] OP_IDENT   = 8'h1A;
    localparam logic [7:0] OP_RESET   = 8'h1C;
    localparam logic [7:0] OP_TOC     = 8'h1E;

    localparam logic [7:0] SB_MOTOR = 8'h02;
    localparam logic [7:0] SB_READ  = 8'h20;
    localparam logic [7:0] SB_SEEK  = 8'h40;
    localparam logic [7:0] SB_PLAY  = 8'h80;

    localparam logic [2:0] RT_DATA = 3'd1;
    localparam logic [2:0] RT_DONE = 3'd2;
    localparam logic [2:0] RT_ACK  = 3'd3;

    function automatic logic op_known(input logic [7:0] op);
        case (op)
            OP_NOP, OP_SETLOC, OP_PLAY, OP_READ, OP_STOP, OP_PAUSE, OP_INIT,
            OP_FILTER, OP_SETMODE, OP_GETMODE, OP_SEEK, OP_IDENT, OP_RESET,
            OP_TOC:  return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [6:0] bcd2bin(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

endpackage

// File: rtl/odc_arg_queue.sv
`timescale 1ns/1ps
module odc_arg_queue #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] din,
    input  logic       clr,
    output logic [7:0] arg0,
    output logic [7:0] arg1,
    output logic [7:0] arg2
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    ent_d [DEPTH];
    logic [7:0]    ent_q [DEPTH];
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        ent_d = ent_q;
        cnt_d = cnt_q;
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) ent_d[i] = '0;
            cnt_d = '0;
        end else if (push && cnt_q < CW'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++)
                if (CW'(i) == cnt_q) ent_d[i] = din;
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
            cnt_q <= '0;
        end else begin
            ent_q <= ent_d;
            cnt_q <= cnt_d;
        end
    end

    assign arg0 = ent_q[0];
    assign arg1 = ent_q[1];
    assign arg2 = ent_q[2];

    a_r8_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (arg0 == 8'h00));

endmodule

// File: rtl/odc_msf_counter.sv
`timescale 1ns/1ps
module odc_msf_counter #(
    parameter int FRAMES  = 75,
    parameter int SECONDS = 60,
    parameter int MINUTES = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [6:0] ld_min,
    input  logic [5:0] ld_sec,
    input  logic [6:0] ld_frm,
    input  logic       step,
    output logic [6:0] min_o,
    output logic [5:0] sec_o,
    output logic [6:0] frm_o
);
    localparam logic [6:0] FRM_LAST = 7'(FRAMES - 1);
    localparam logic [5:0] SEC_LAST = 6'(SECONDS - 1);
    localparam logic [6:0] MIN_LAST = 7'(MINUTES - 1);

    logic [6:0] min_d, min_q, frm_d, frm_q;
    logic [5:0] sec_d, sec_q;

    always_comb begin
        min_d = min_q;
        sec_d = sec_q;
        frm_d = frm_q;
        if (load) begin
            min_d = ld_min;
            sec_d = ld_sec;
            frm_d = ld_frm;
        end else if (step) begin
            if (frm_q == FRM_LAST) begin
                frm_d = '0;
                if (sec_q == SEC_LAST) begin
                    sec_d = '0;
                    min_d = (min_q == MIN_LAST) ? '0 : min_q + 1'b1;
                end else begin
                    sec_d = sec_q + 1'b1;
                end
            end else begin
                frm_d = frm_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q <= '0;
            sec_q <= '0;
            frm_q <= '0;
        end else begin
            min_q <= min_d;
            sec_q <= sec_d;
            frm_q <= frm_d;
        end
    end

    assign min_o = min_q;
    assign sec_o = sec_q;
    assign frm_o = frm_q;

    a_r9_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && frm_o == FRM_LAST) |=> (frm_o == 7'd0));

    a_r9_second_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && frm_o == FRM_LAST && sec_o != SEC_LAST) |=> (sec_o == $past(sec_o) + 6'd1));

endmodule

// File: rtl/odc_cmd_sequencer.sv
`timescale 1ns/1ps
module odc_cmd_sequencer
    import odc_pkg::*;
#(
    parameter int ACK_DELAY     = 32'h800,
    parameter int PAUSE_DELAY   = 32'h40000,
    parameter int READ_INTERVAL = 16384,
    parameter int ARG_DEPTH     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       param_wr,
    input  logic [7:0] param_in,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_in,
    input  logic       irq_mask_wr,
    input  logic [2:0] irq_mask_in,
    input  logic       irq_ack,
    input  logic       sector_eof,
    input  logic [2:0] resp_idx,
    output logic       busy_o,
    output logic [7:0] status_o,
    output logic       resp_valid_o,
    output logic [2:0] resp_type_o,
    output logic [2:0] resp_len_o,
    output logic [7:0] resp_byte_o,
    output logic       irq_o,
    output logic [6:0] msf_min_o,
    output logic [5:0] msf_sec_o,
    output logic [6:0] msf_frm_o
);
    localparam int TW = $clog2(PAUSE_DELAY + 1);
    localparam int RW = $clog2(READ_INTERVAL + 1);
    localparam logic [TW-1:0] ACK_LD   = TW'(ACK_DELAY - 1);
    localparam logic [TW-1:0] PAUSE_LD = TW'(PAUSE_DELAY - 1);
    localparam logic [RW-1:0] FULL_LD  = RW'(READ_INTERVAL - 1);
    localparam logic [RW-1:0] HALF_LD  = RW'(READ_INTERVAL / 2 - 1);

    typedef struct packed {
        stage_e          stage;
        logic [7:0]      cmd;
        logic [TW-1:0]   timer;
        logic [RW-1:0]   rtimer;
        logic [7:0]      status;
        logic [7:0]      mode;
        logic [7:0]      file;
        logic [7:0]      chan;
        logic [7:0]      a0;
        logic [7:0]      a1;
        logic [7:0]      a2;
        logic            rvalid;
        logic [2:0]      rtype;
        logic [2:0]      rlen;
        logic [47:0]     rbuf;
        logic [2:0]      mask;
    } seq_t;

    seq_t        d, q;
    logic        accept, cmd_fire, msf_load, msf_step;
    logic [7:0]  s;
    logic [RW-1:0] read_ld;
    logic [7:0]  arg0, arg1, arg2;

    odc_arg_queue #(.DEPTH(ARG_DEPTH)) u_args (
        .clk(clk), .rst_n(rst_n), .push(param_wr), .din(param_in), .clr(accept),
        .arg0(arg0), .arg1(arg1), .arg2(arg2)
    );

    odc_msf_counter u_msf (
        .clk(clk), .rst_n(rst_n), .load(msf_load),
        .ld_min(bcd2bin(q.a0)), .ld_sec(6'(bcd2bin(q.a1))), .ld_frm(bcd2bin(q.a2)),
        .step(msf_step), .min_o(msf_min_o), .sec_o(msf_sec_o), .frm_o(msf_frm_o)
    );

    always_comb begin
        d        = q;
        s        = q.status;
        msf_load = 1'b0;
        msf_step = 1'b0;
        cmd_fire = 1'b0;
        read_ld  = q.mode[7] ? HALF_LD : FULL_LD;
        accept   = cmd_wr && (q.stage != ST_ACK) && op_known(cmd_in);

        if (irq_ack)     d.rvalid = 1'b0;
        if (irq_mask_wr) d.mask   = irq_mask_in;

        if (accept) begin
            d.stage = ST_ACK;
            d.cmd   = cmd_in;
            d.timer = (cmd_in == OP_PAUSE) ? PAUSE_LD : ACK_LD;
            d.a0    = arg0;
            d.a1    = arg1;
            d.a2    = arg2;
        end else if (q.stage != ST_IDLE) begin
            if (q.timer != '0) begin
                d.timer = q.timer - 1'b1;
            end else if (!q.rvalid) begin
                cmd_fire = 1'b1;
                d.rvalid = 1'b1;
                d.rlen   = 3'd1;
                d.rtype  = RT_ACK;
                d.stage  = ST_IDLE;
                d.rbuf   = '0;
                if (q.stage == ST_DONE) begin
                    s = (q.status | SB_MOTOR) & ~SB_SEEK;
                    d.rtype = RT_DONE;
                    d.rbuf[7:0] = s;
                end else begin
                    case (q.cmd)
                        OP_SETLOC: begin
                            s = s | SB_MOTOR;
                            msf_load = 1'b1;
                            d.rbuf[7:0] = s;
                        end
                        OP_PLAY: begin
                            s = s | SB_MOTOR;
                            d.rbuf[7:0] = s;
                            s = s | SB_PLAY;
                        end
                        OP_READ: begin
                            s = s | SB_MOTOR;
                            d.rbuf[7:0] = s;
                            s = s | SB_READ;
                            d.rtimer = read_ld;
                        end
                        OP_STOP: begin
                            s = s & ~(SB_MOTOR | SB_READ | SB_PLAY);
                            d.rbuf[7:0] = s;
                            d.rtype = RT_DONE;
                        end
                        OP_PAUSE: begin
                            d.rbuf[7:0] = s;
                            s = s & ~(SB_READ | SB_PLAY);
                            d.stage = ST_DONE;
                            d.timer = ACK_LD;
                        end
                        OP_INIT, OP_RESET: begin
                            s = SB_MOTOR;
                            d.rbuf[7:0] = s;
                            if (q.cmd == OP_INIT) begin
                                d.stage = ST_DONE;
                                d.timer = ACK_LD;
                            end
                        end
                        OP_SEEK, OP_IDENT, OP_TOC: begin
                            s = s | SB_MOTOR | ((q.cmd == OP_SEEK) ? SB_SEEK : 8'h00);
                            d.rbuf[7:0] = s;
                            d.stage = ST_DONE;
                            d.timer = ACK_LD;
                        end
                        OP_FILTER, OP_SETMODE, OP_GETMODE: begin
                            s = s | SB_MOTOR;
                            if (q.cmd == OP_FILTER) begin
                                d.file = q.a0;
                                d.chan = q.a1;
                            end
                            if (q.cmd == OP_SETMODE) d.mode = q.a0;
                            d.rbuf[7:0] = s;
                            if (q.cmd == OP_GETMODE) begin
                                d.rbuf[31:8] = {q.chan, q.file, q.mode};
                                d.rlen = 3'd6;
                            end
                        end
                        default: d.rbuf[7:0] = s;
                    endcase
                end
                d.status = s;
            end
        end

        if (!cmd_fire && q.status[5]) begin
            if (q.rtimer != '0) begin
                d.rtimer = q.rtimer - 1'b1;
            end else if (!q.rvalid) begin
                msf_step = 1'b1;
                d.rvalid = 1'b1;
                d.rtype  = RT_DATA;
                d.rlen   = 3'd1;
                d.rbuf   = {40'd0, q.status};
                d.rtimer = read_ld;
                if (sector_eof && q.mode[1]) d.status = q.status & ~SB_READ;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        resp_byte_o = '0;
        for (int i = 0; i < 6; i++)
            if (resp_idx == 3'(i) && 3'(i) < q.rlen) resp_byte_o = q.rbuf[8*i +: 8];
    end

    assign busy_o       = (q.stage == ST_ACK);
    assign status_o     = q.status;
    assign resp_valid_o = q.rvalid;
    assign resp_type_o  = q.rtype;
    assign resp_len_o   = q.rlen;
    assign irq_o        = q.rvalid && ((q.rtype & q.mask) != 3'd0);

    a_r1_busy_drop_posts: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> resp_valid_o);

    a_r3_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmd_wr) |=> $stable(q.cmd));

    a_r12_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && resp_valid_o) |=> !resp_valid_o);

    a_r9_read_needs_motor: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[5] |-> status_o[1]);

    a_r6_done_clears_seek: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(resp_valid_o) && resp_type_o == RT_DONE) |-> !status_o[6]);

endmodule

// File: tb/odc_cmd_sequencer_test.sv
`timescale 1ns/1ps
module odc_cmd_sequencer_test;
    localparam int AD = 8;
    localparam int PD = 40;
    localparam int RI = 20;
    localparam int NSEC = 90;

    logic clk = 1'b0;
    logic rst_n, param_wr, cmd_wr, irq_mask_wr, irq_ack, sector_eof;
    logic [7:0] param_in, cmd_in;
    logic [2:0] irq_mask_in, resp_idx;
    logic busy_o, resp_valid_o, irq_o;
    logic [7:0] status_o, resp_byte_o;
    logic [2:0] resp_type_o, resp_len_o;
    logic [6:0] msf_min_o, msf_frm_o;
    logic [5:0] msf_sec_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    odc_cmd_sequencer #(.ACK_DELAY(AD), .PAUSE_DELAY(PD), .READ_INTERVAL(RI), .ARG_DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .param_wr(param_wr), .param_in(param_in),
        .cmd_wr(cmd_wr), .cmd_in(cmd_in), .irq_mask_wr(irq_mask_wr), .irq_mask_in(irq_mask_in),
        .irq_ack(irq_ack), .sector_eof(sector_eof), .resp_idx(resp_idx),
        .busy_o(busy_o), .status_o(status_o), .resp_valid_o(resp_valid_o),
        .resp_type_o(resp_type_o), .resp_len_o(resp_len_o), .resp_byte_o(resp_byte_o),
        .irq_o(irq_o), .msf_min_o(msf_min_o), .msf_sec_o(msf_sec_o), .msf_frm_o(msf_frm_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        param_wr = 1'b1; param_in = b; tick(1); param_wr = 1'b0;
    endtask

    task automatic issue(input logic [7:0] c);
        cmd_wr = 1'b1; cmd_in = c; tick(1); cmd_wr = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
    endtask

    task automatic set_mask(input logic [2:0] m);
        irq_mask_wr = 1'b1; irq_mask_in = m; tick(1); irq_mask_wr = 1'b0;
    endtask

    task automatic wait_resp(output int c);
        c = 0;
        while (!resp_valid_o && c < 500) begin tick(1); c++; end
    endtask

    task automatic chk_byte(input string tag, input int idx, input int exp);
        resp_idx = 3'(idx);
        #1;
        chk(tag, int'(resp_byte_o), exp);
    endtask

    task automatic chk_msf(input string tag, input int t);
        chk({tag, " min"}, int'(msf_min_o), (t / 4500) % 100);
        chk({tag, " sec"}, int'(msf_sec_o), (t / 75) % 60);
        chk({tag, " frm"}, int'(msf_frm_o), t % 75);
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R1 actual=timeout expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int c;
        int t;
        rst_n = 1'b0; param_wr = 0; cmd_wr = 0; irq_mask_wr = 0; irq_ack = 0;
        sector_eof = 0; param_in = 0; cmd_in = 0; irq_mask_in = 0; resp_idx = 0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 reset busy", busy_o, 0);
        chk("R1 reset status", status_o, 0);
        chk("R1 reset valid", resp_valid_o, 0);
        chk("R1 reset irq", irq_o, 0);
        chk_msf("R1 reset msf", 0);

        // R1 exact acknowledge timing, R12 masking
        issue(8'h01);
        chk("R1 busy set", busy_o, 1);
        tick(AD - 1);
        chk("R1 busy before delay", busy_o, 1);
        chk("R1 no resp before delay", resp_valid_o, 0);
        tick(1);
        chk("R1 busy cleared", busy_o, 0);
        chk("R1 resp posted", resp_valid_o, 1);
        chk("R12 ack type", resp_type_o, 3);
        chk("R12 irq masked", irq_o, 0);
        set_mask(3'b010);
        chk("R12 irq enabled", irq_o, 1);
        ack();
        chk("R12 ack releases irq", irq_o, 0);
        chk("R12 ack releases resp", resp_valid_o, 0);

        // R3 unknown code
        issue(8'h55);
        chk("R3 unknown no busy", busy_o, 0);
        tick(AD + 2);
        chk("R3 unknown no resp", resp_valid_o, 0);

        // R3 command while busy ignored
        push(8'h00);
        issue(8'h0E);
        tick(2);
        issue(8'h0F);
        wait_resp(c);
        chk("R3 first cmd timing kept", c, AD - 3);
        chk("R3 response is set-mode length", resp_len_o, 1);
        chk("R4 motor set", status_o, 8'h02);
        ack();
        tick(AD + 2);
        chk("R3 ignored cmd never answers", resp_valid_o, 0);

        // R11 filter, mode, get-mode
        push(8'h11); push(8'h22); issue(8'h0D); wait_resp(c); ack();
        push(8'h83); issue(8'h0E); wait_resp(c); ack();
        issue(8'h0F);
        wait_resp(c);
        chk("R1 get-mode delay", c, AD);
        chk("R11 length", resp_len_o, 6);
        chk_byte("R11 byte0 status", 0, 8'h02);
        chk_byte("R11 byte1 mode", 1, 8'h83);
        chk_byte("R11 byte2 file", 2, 8'h11);
        chk_byte("R11 byte3 channel", 3, 8'h22);
        chk_byte("R11 byte4", 4, 0);
        chk_byte("R11 byte5", 5, 0);
        chk_byte("R11 beyond length", 6, 0);
        ack();

        // R8 set-location from BCD
        push(8'h00); push(8'h59); push(8'h73); issue(8'h02);
        wait_resp(c);
        chk_msf("R8 setloc", 59 * 75 + 73);
        ack();

        // R9 read with halved interval, address sweep across carries
        issue(8'h06);
        wait_resp(c);
        chk("R9 read ack delay", c, AD);
        chk_byte("R9 read ack byte", 0, 8'h02);
        chk("R9 reading bit set", status_o, 8'h22);
        ack();
        t = 59 * 75 + 73;
        for (int i = 1; i <= NSEC; i++) begin
            wait_resp(c);
            chk("R9 half interval", c, RI / 2 - 1);
            chk("R12 data type", resp_type_o, 1);
            chk_byte("R9 data byte", 0, 8'h22);
            chk_msf("R9 sweep", t + i);
            ack();
        end

        // R10 autopause
        sector_eof = 1'b1;
        wait_resp(c);
        chk("R10 last sector timing", c, RI / 2 - 1);
        chk_byte("R10 last data byte", 0, 8'h22);
        chk("R10 reading cleared", status_o, 8'h02);
        ack();
        sector_eof = 1'b0;
        tick(3 * RI);
        chk("R10 no more sectors", resp_valid_o, 0);
        chk_msf("R10 address frozen", t + NSEC + 1);

        // R9 full interval
        push(8'h00); issue(8'h0E); wait_resp(c); ack();
        issue(8'h06); wait_resp(c); ack();
        wait_resp(c);
        chk("R9 full interval", c, RI - 1);
        chk_msf("R9 one step", t + NSEC + 2);
        ack();

        // R7 stop, R12 type/mask
        set_mask(3'b001);
        issue(8'h08);
        wait_resp(c);
        chk("R7 stop delay", c, AD);
        chk("R7 stop type", resp_type_o, 2);
        chk_byte("R7 stop byte", 0, 8'h00);
        chk("R7 stop status", status_o, 8'h00);
        chk("R12 done masked", irq_o, 0);
        set_mask(3'b111);
        chk("R12 done enabled", irq_o, 1);
        ack();
        tick(2 * RI);
        chk("R7 reading halted", resp_valid_o, 0);

        // R4 play
        issue(8'h03);
        wait_resp(c);
        chk_byte("R4 play ack byte", 0, 8'h02);
        chk("R4 playing set", status_o, 8'h82);
        ack();

        // R6/R5 seek
        issue(8'h15);
        wait_resp(c);
        chk("R6 seek ack type", resp_type_o, 3);
        chk_byte("R6 seek ack byte", 0, 8'hC2);
        chk("R6 seek status", status_o, 8'hC2);
        ack();
        wait_resp(c);
        chk("R5 completion delay", c, AD - 1);
        chk("R5 completion type", resp_type_o, 2);
        chk_byte("R6 seek done byte", 0, 8'h82);
        chk("R6 seek bit cleared", status_o, 8'h82);
        ack();

        // R2 pause, R5 deferred completion
        issue(8'h09);
        wait_resp(c);
        chk("R2 pause delay", c, PD);
        chk_byte("R2 pause ack byte", 0, 8'h82);
        chk("R2 pause status", status_o, 8'h02);
        tick(2 * AD);
        chk("R5 held response valid", resp_valid_o, 1);
        chk("R5 held response type", resp_type_o, 3);
        ack();
        chk("R5 released", resp_valid_o, 0);
        tick(1);
        chk("R5 deferred completion", resp_valid_o, 1);
        chk("R5 deferred type", resp_type_o, 2);
        chk_byte("R2 pause done byte", 0, 8'h02);
        ack();

        // R7 init, R5 two-stage
        issue(8'h03); wait_resp(c); ack();
        issue(8'h0A);
        wait_resp(c);
        chk_byte("R7 init byte", 0, 8'h02);
        chk("R7 init status", status_o, 8'h02);
        ack();
        wait_resp(c);
        chk("R5 init completion delay", c, AD - 1);
        chk("R5 init completion type", resp_type_o, 2);
        ack();

        // R5 table of contents
        issue(8'h1E); wait_resp(c); ack();
        wait_resp(c);
        chk("R5 toc completion delay", c, AD - 1);
        chk("R5 toc completion type", resp_type_o, 2);
        ack();

        // R7 reset, single stage
        issue(8'h03); wait_resp(c); ack();
        issue(8'h1C);
        wait_resp(c);
        chk("R7 reset status", status_o, 8'h02);
        chk("R7 reset type", resp_type_o, 3);
        ack();
        tick(AD + 2);
        chk("R7 reset no second", resp_valid_o, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule